// File: doc/BRIEF.md
# USB PHY Power and Mode Controller

This block is a small configuration register that owns the power state of an on-chip USB 2.0 PHY. It keeps the PHY reset, the two power-down controls and the PLL enable, and it reports when the PHY clock is stable. It also decides what the USB controller sees on its VBUS-valid and ID inputs. These come either from the real PHY comparators or from fixed values that make the controller act as host or as device.

Software brings the PHY up by clearing reset and both power-downs and setting the PLL enable. It then polls the clock-good status. The PLL is modelled as a lock counter of `LOCK_CYCLES` clocks. The register also holds the clock-source select and the suspend control of a neighbouring full-speed (USB 1.1) host. While that host takes its reference clock from this PHY, a power-down request is refused, and a sticky status flag records the refusal.

Top module: `usb_phy_pwr_ctrl`

## Requirements
- R1: After reset the config register (address 0) reads 0x07: bit0 PHY reset = 1, bit1 PHY power-down = 1, bit2 OTG power-down = 1, bit3 PLL enable = 0, bits5:4 mode = 00, bit6 full-speed clock select = 0, bit7 full-speed suspend control = 0. The status register (address 1) reads 0x00.
- R2: Once the config register holds PLL enable = 1 with reset and both power-downs at 0, status bit0 (clock-good) reads 1 exactly `LOCK_CYCLES` clock edges after the edge that stored that config, and 0 before then.
- R3: Clock-good reads 0 from the first cycle in which the stored config has PLL enable = 0, reset = 1 or either power-down = 1.
- R4: A power-down request is a config write with bit1 or bit2 set. When it is granted, both power-down bits become 1. A config write with bits 1 and 2 both clear sets both power-down bits to 0.
- R5: A power-down request made while the PHY is powered up is refused when the stored full-speed clock select is 0 and the stored full-speed suspend control is 1. Both power-down bits then stay 0, and the other fields of the same write are still stored.
- R6: A refusal sets status bit1, which stays set until a status write (address 1) with bit1 = 1. A status write with bit1 = 0 leaves it unchanged.
- R7: Mode 01 (force host) drives VBUS-valid = 1 and ID = 0, whatever the comparators show.
- R8: Mode 10 (force device) drives VBUS-valid = 1 and ID = 1, whatever the comparators show.
- R9: Modes 00 and 11 pass the VBUS and ID comparator inputs to the outputs unchanged.
- R10: Reads are combinational. Address 0 returns the config fields at the positions given in R1. Address 1 returns {6'b0, refused, clock-good}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 config, 1 status |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 config, 1 status |
| rd_data | output | 8 | Read data |
| vbus_cmp_i | input | 1 | VBUS-valid comparator output from the PHY |
| id_cmp_i | input | 1 | ID comparator output from the PHY |
| vbus_valid_o | output | 1 | VBUS-valid presented to the controller |
| id_o | output | 1 | ID presented to the controller |

## Verification
A single config write can carry a power-down request and a change of mode or PLL enable at the same time. If the write is refused, the refusal logic and the field update act in the same cycle. The bench sends such a write while the full-speed host holds the clock. It then checks that the new mode is already forcing the outputs, that both power-down bits stayed clear and that the sticky flag is set. The write that finally grants power-down lands while the PLL is locked, and the bench checks that clock-good drops on the next cycle.

// File: rtl/usb_phy_pwr_ctrl.sv
module usb_phy_pwr_ctrl #(
  parameter int LOCK_CYCLES = 2400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_addr,
  output logic [7:0] rd_data,
  input  logic       vbus_cmp_i,
  input  logic       id_cmp_i,
  output logic       vbus_valid_o,
  output logic       id_o
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  logic          phy_rst_q, phy_pd_q, otg_pd_q, pll_q, fs_sel_q, fs_susp_q;
  logic [1:0]    mode_q;
  logic          refused_q, locked_q;
  logic [CW-1:0] cnt_q;

  wire cfg_wr  = wr_en & ~wr_addr;
  wire st_wr   = wr_en & wr_addr;
  wire pd_req  = wr_data[1] | wr_data[2];
  wire fs_hold = ~fs_sel_q & fs_susp_q;
  wire refuse  = cfg_wr & pd_req & ~(phy_pd_q | otg_pd_q) & fs_hold;
  wire running = pll_q & ~phy_pd_q & ~otg_pd_q & ~phy_rst_q;
  wire clk_good = locked_q & running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_rst_q <= 1'b1;
      phy_pd_q  <= 1'b1;
      otg_pd_q  <= 1'b1;
      pll_q     <= 1'b0;
      mode_q    <= 2'b00;
      fs_sel_q  <= 1'b0;
      fs_susp_q <= 1'b0;
    end else if (cfg_wr) begin
      phy_rst_q <= wr_data[0];
      pll_q     <= wr_data[3];
      mode_q    <= wr_data[5:4];
      fs_sel_q  <= wr_data[6];
      fs_susp_q <= wr_data[7];
      if (!refuse) begin
        phy_pd_q <= pd_req;
        otg_pd_q <= pd_req;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   refused_q <= 1'b0;
    else if (refuse)              refused_q <= 1'b1;
    else if (st_wr && wr_data[1]) refused_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (!running) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      locked_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    case (mode_q)
      2'b01:   begin vbus_valid_o = 1'b1;       id_o = 1'b0;     end
      2'b10:   begin vbus_valid_o = 1'b1;       id_o = 1'b1;     end
      default: begin vbus_valid_o = vbus_cmp_i; id_o = id_cmp_i; end
    endcase
  end

  assign rd_data = rd_addr ? {6'b0, refused_q, clk_good}
                           : {fs_susp_q, fs_sel_q, mode_q, pll_q, otg_pd_q, phy_pd_q, phy_rst_q};

  p_good_needs_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_good |-> $past(running));
  p_drop_on_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !clk_good);
  p_refuse_keeps_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && pd_req && !phy_pd_q && !otg_pd_q && !fs_sel_q && fs_susp_q)
      |=> (!phy_pd_q && !otg_pd_q && refused_q));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (refused_q && !(st_wr && wr_data[1])) |=> refused_q);
  p_host_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01) |-> (vbus_valid_o && !id_o));
  p_dev_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b10) |-> (vbus_valid_o && id_o));
  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |-> (vbus_valid_o == vbus_cmp_i && id_o == id_cmp_i));
endmodule

// File: tb/sim_usb_phy_pwr_ctrl.sv
module sim_usb_phy_pwr_ctrl;
  localparam int LOCK = 8;
  // {mode[1:0], vbus_in, id_in, exp_vbus, exp_id}
  localparam logic [5:0] VEC [8] = '{
    6'b00_01_01, 6'b00_10_10, 6'b01_01_10, 6'b01_11_10,
    6'b10_00_11, 6'b10_10_11, 6'b11_11_11, 6'b11_00_00};

  logic clk = 0, rst_n = 0, wr_en = 0, wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic vbus_cmp_i = 0, id_cmp_i = 0, vbus_valid_o, id_o;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  usb_phy_pwr_ctrl #(.LOCK_CYCLES(LOCK)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .vbus_cmp_i(vbus_cmp_i), .id_cmp_i(id_cmp_i),
    .vbus_valid_o(vbus_valid_o), .id_o(id_o));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    rd_addr = a; #1 d = rd_data;
  endtask

  initial begin
    repeat (300) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, v); chk("R1 cfg reset", v, 8'h07);
    rd(1, v); chk("R1 status reset", v, 8'h00);

    foreach (VEC[i]) begin
      wr(0, 8'h07 | {2'b0, VEC[i][5:4], 4'b0});
      vbus_cmp_i = VEC[i][3]; id_cmp_i = VEC[i][2];
      #1;
      chk(VEC[i][5:4] == 2'b01 ? "R7 host force" : VEC[i][5:4] == 2'b10 ? "R8 device force" : "R9 pass",
          {6'b0, vbus_valid_o, id_o}, {6'b0, VEC[i][1:0]});
    end

    wr(0, 8'h08);
    rd(0, v); chk("R4 pd cleared", v, 8'h08);
    repeat (LOCK - 1) @(negedge clk);
    rd(1, v); chk("R2 not yet good", v, 8'h00);
    @(negedge clk);
    rd(1, v); chk("R2 good at lock", v, 8'h01);
    wr(0, 8'h00);
    rd(1, v); chk("R3 pll off drops good", v, 8'h00);

    wr(0, 8'h08);
    repeat (LOCK) @(negedge clk);
    rd(1, v); chk("R2 relock", v, 8'h01);
    wr(0, 8'h09);
    rd(1, v); chk("R3 reset drops good", v, 8'h00);
    wr(0, 8'h08);
    repeat (LOCK) @(negedge clk);
    wr(0, 8'h0A);
    rd(0, v); chk("R4 both pd set", v, 8'h0E);
    rd(1, v); chk("R3 pd drops good", v, 8'h00);

    wr(0, 8'h88);
    repeat (LOCK) @(negedge clk);
    wr(0, 8'h9A);
    rd(0, v); chk("R5 refused keeps pd, stores mode", v, 8'h98);
    chk("R5 mode applied with refusal", {6'b0, vbus_valid_o, id_o}, 8'h02);
    rd(1, v); chk("R6 refusal flag + good kept", v, 8'h03);
    wr(1, 8'h00);
    rd(1, v); chk("R6 zero write keeps flag", v, 8'h03);
    wr(1, 8'h02);
    rd(1, v); chk("R6 flag cleared", v, 8'h01);

    wr(0, 8'hC8);
    wr(0, 8'hCA);
    rd(0, v); chk("R5 granted with own clock", v, 8'hCE);
    rd(1, v); chk("R10 status after grant", v, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule